// File: doc/BRIEF.md
# Unknown-Tolerant XOR Space Compactor with Response Judge

This block folds a wide slice of test response bits into a narrower set of compacted bits, one slice per clock, through a fixed XOR network. The wiring of that network comes from a dependency matrix given as a parameter. Each incoming response bit has a companion flag that marks its value as unknown. Each compacted bit carries a matching unknown flag. That flag is raised whenever any response bit feeding that compacted bit is unknown, so an unknown never disappears silently into an XOR.

A registered judge stage compares the compacted bits against expected values and expected-unknown flags supplied by the tester side. For each compacted bit it reports one of three results: pass, fail, or ignore. A bit is ignored when its expected value is unknown or its compacted value is flagged unknown. A strobe at the start of a test pattern and another at its end bracket a pattern. At the end strobe the block publishes a sticky verdict that says whether any non-ignored bit mismatched during that pattern.

The matrix is packed as `M_OUT` bits per row, with rows stacked from row 0 at the least significant end. The elaboration step rejects a matrix that has an empty row, and it rejects `M_OUT` not below `N_IN`.

Top module: `xtol_compactor`

## Requirements
- R1: `cmp_val[j]` equals the XOR of every `resp_val[i]` for which matrix bit `MATRIX[i*M_OUT + j]` is 1. The output is combinational, in the same cycle as the input.
- R2: `cmp_unk[j]` is 1 exactly when at least one `resp_unk[i]` with `MATRIX[i*M_OUT + j]` = 1 is set. With no unknown inputs, every `cmp_unk` bit is 0.
- R3: One cycle after a cycle with `cmp_en` = 1, `res_vld` is 1 and each 2-bit field `res_code[2j+1:2j]` reads 2'b01 (pass) when `cmp_val[j]` equals `exp_val[j]` and neither unknown flag is set. It reads 2'b10 (fail) when they differ and neither flag is set.
- R4: A compacted bit whose `exp_unk[j]` is 1 gets code 2'b11 (ignore) whatever its actual and expected values, and it never contributes a fail.
- R5: A compacted bit whose `cmp_unk[j]` is 1 also gets code 2'b11 (ignore), whatever the values.
- R6: One cycle after a cycle with `cmp_en` = 0, `res_vld` is 0 and all of `res_code` is 2'b00 (idle).
- R7: `cyc_fail` is 1 in exactly those cycles where at least one field of `res_code` is 2'b10.
- R8: One cycle after `pat_end`, `pat_done` pulses high for one cycle. At the same time `pat_fail` takes the OR of all fails from compares made since the last `pat_start`, counting compares made in the `pat_start` cycle and in the `pat_end` cycle.
- R9: `pat_fail` holds its value until a `pat_start` arrives without `pat_end`. In the cycle after that `pat_start`, `pat_fail` is 0.
- R10: While `rst_n` is low, all registered outputs (`res_vld`, `res_code`, `cyc_fail`, `pat_done`, `pat_fail`) are 0.
- R11: Every matrix row has at least one 1, and `M_OUT` < `N_IN`. The elaboration step enforces both. As a result, a response with a single bit set, and no unknowns, drives a nonzero `cmp_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resp_val | input | N_IN | Uncompacted response values |
| resp_unk | input | N_IN | Unknown flags for the response values |
| exp_val | input | M_OUT | Expected compacted values |
| exp_unk | input | M_OUT | Expected-unknown flags |
| cmp_en | input | 1 | Compare the current slice |
| pat_start | input | 1 | First slice of a test pattern |
| pat_end | input | 1 | Last slice of a test pattern |
| cmp_val | output | M_OUT | Compacted values |
| cmp_unk | output | M_OUT | Compacted unknown flags |
| res_vld | output | 1 | Registered result is from a compare |
| res_code | output | 2*M_OUT | Per-bit result: 00 idle, 01 pass, 10 fail, 11 ignore |
| cyc_fail | output | 1 | Any bit failed in the registered result |
| pat_done | output | 1 | One-cycle pulse after pattern end |
| pat_fail | output | 1 | Sticky verdict for the last finished pattern |

## Verification
The bench builds the block with 8 response bits and 5 compacted bits. It uses a matrix in which every row has weight three and no two rows are equal. This reaches both single-input and multi-input unknown propagation, and it makes every single-bit response reach three outputs. A 5-bit result vector is small enough for the bench to drive pass, fail and ignore into distinct fields within one slice. The pattern tests place fails in the start cycle, in the end cycle and in neither, to pin the accumulation window.

// File: rtl/xcmp_pkg.sv
package xcmp_pkg;

   typedef enum logic [1:0] {
      RC_IDLE = 2'b00,
      RC_PASS = 2'b01,
      RC_FAIL = 2'b10,
      RC_IGN  = 2'b11
   } res_code_e;

   localparam int unsigned RC_W = 2;

endpackage

// File: rtl/xcmp_xor_net.sv
module xcmp_xor_net #(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned M_OUT = 5,
   parameter logic [N_IN*M_OUT-1:0] MATRIX = '0
) (
   input  logic [N_IN-1:0]  in_val,
   input  logic [N_IN-1:0]  in_unk,
   output logic [M_OUT-1:0] out_val,
   output logic [M_OUT-1:0] out_unk
);

   for (genvar j = 0; j < M_OUT; j++) begin : g_col
      logic [N_IN-1:0] sel;
      for (genvar i = 0; i < N_IN; i++) begin : g_row
         assign sel[i] = MATRIX[i*M_OUT + j];
      end
      assign out_val[j] = ^(in_val & sel);
      assign out_unk[j] = |(in_unk & sel);
   end

endmodule

// File: rtl/xcmp_judge.sv
module xcmp_judge
   import xcmp_pkg::*;
#(
   parameter int unsigned M_OUT = 5
) (
   input  logic                  en,
   input  logic [M_OUT-1:0]      act_val,
   input  logic [M_OUT-1:0]      act_unk,
   input  logic [M_OUT-1:0]      exp_val,
   input  logic [M_OUT-1:0]      exp_unk,
   output logic [RC_W*M_OUT-1:0] code,
   output logic                  any_fail
);

   logic [M_OUT-1:0] bit_fail;

   for (genvar j = 0; j < M_OUT; j++) begin : g_bit
      res_code_e c;
      always_comb begin
         if (!en)                          c = RC_IDLE;
         else if (exp_unk[j] || act_unk[j]) c = RC_IGN;
         else if (act_val[j] == exp_val[j]) c = RC_PASS;
         else                              c = RC_FAIL;
      end
      assign code[RC_W*j +: RC_W] = c;
      assign bit_fail[j]          = (c == RC_FAIL);
   end

   assign any_fail = |bit_fail;

endmodule

// File: rtl/xcmp_verdict.sv
module xcmp_verdict
   import xcmp_pkg::*;
#(
   parameter int unsigned M_OUT = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [RC_W*M_OUT-1:0] code_d,
   input  logic                  fail_d,
   input  logic                  pat_start,
   input  logic                  pat_end,
   output logic                  res_vld,
   output logic [RC_W*M_OUT-1:0] res_code,
   output logic                  cyc_fail,
   output logic                  pat_done,
   output logic                  pat_fail
);

   logic acc_q;
   logic acc_base;
   logic acc_next;

   assign acc_base = pat_start ? 1'b0 : acc_q;
   assign acc_next = acc_base | fail_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_code <= '0;
         cyc_fail <= 1'b0;
      end else begin
         res_vld  <= en;
         res_code <= code_d;
         cyc_fail <= fail_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= 1'b0;
         pat_done <= 1'b0;
         pat_fail <= 1'b0;
      end else begin
         acc_q    <= acc_next;
         pat_done <= pat_end;
         if (pat_end)        pat_fail <= acc_next;
         else if (pat_start) pat_fail <= 1'b0;
      end
   end

endmodule

// File: rtl/xtol_compactor.sv
module xtol_compactor
   import xcmp_pkg::*;
#(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned M_OUT = 5,
   parameter logic [N_IN*M_OUT-1:0] MATRIX = {
      5'b10110, 5'b01110, 5'b11001, 5'b10101,
      5'b01101, 5'b10011, 5'b01011, 5'b00111
   }
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        resp_val,
   input  logic [N_IN-1:0]        resp_unk,
   input  logic [M_OUT-1:0]       exp_val,
   input  logic [M_OUT-1:0]       exp_unk,
   input  logic                   cmp_en,
   input  logic                   pat_start,
   input  logic                   pat_end,
   output logic [M_OUT-1:0]       cmp_val,
   output logic [M_OUT-1:0]       cmp_unk,
   output logic                   res_vld,
   output logic [2*M_OUT-1:0]     res_code,
   output logic                   cyc_fail,
   output logic                   pat_done,
   output logic                   pat_fail
);

   localparam int unsigned CODE_W = RC_W * M_OUT;

   // R11: structural legality of the parameters
   if (M_OUT >= N_IN) begin : g_bad_ratio
      $error("xtol_compactor: M_OUT must be below N_IN");
   end
   if (M_OUT == 0) begin : g_bad_width
      $error("xtol_compactor: M_OUT must be nonzero");
   end
   for (genvar r = 0; r < N_IN; r++) begin : g_row_chk
      if (MATRIX[r*M_OUT +: M_OUT] == '0) begin : g_empty
         $error("xtol_compactor: matrix row without any connection");
      end
   end

   logic [CODE_W-1:0] code_d;
   logic              fail_d;

   xcmp_xor_net #(
      .N_IN   (N_IN),
      .M_OUT  (M_OUT),
      .MATRIX (MATRIX)
   ) net_i (
      .in_val  (resp_val),
      .in_unk  (resp_unk),
      .out_val (cmp_val),
      .out_unk (cmp_unk)
   );

   xcmp_judge #(
      .M_OUT (M_OUT)
   ) judge_i (
      .en       (cmp_en),
      .act_val  (cmp_val),
      .act_unk  (cmp_unk),
      .exp_val  (exp_val),
      .exp_unk  (exp_unk),
      .code     (code_d),
      .any_fail (fail_d)
   );

   xcmp_verdict #(
      .M_OUT (M_OUT)
   ) verdict_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cmp_en),
      .code_d    (code_d),
      .fail_d    (fail_d),
      .pat_start (pat_start),
      .pat_end   (pat_end),
      .res_vld   (res_vld),
      .res_code  (res_code),
      .cyc_fail  (cyc_fail),
      .pat_done  (pat_done),
      .pat_fail  (pat_fail)
   );

endmodule

// File: rtl/xtol_compactor_chk.sv
module xtol_compactor_chk #(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned M_OUT = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_IN-1:0]    resp_unk,
   input logic [M_OUT-1:0]   exp_unk,
   input logic               cmp_en,
   input logic               pat_start,
   input logic               pat_end,
   input logic [M_OUT-1:0]   cmp_unk,
   input logic               res_vld,
   input logic [2*M_OUT-1:0] res_code,
   input logic               cyc_fail,
   input logic               pat_done,
   input logic               pat_fail
);

   logic [M_OUT-1:0] seen_fail;
   for (genvar j = 0; j < M_OUT; j++) begin : g_sf
      assign seen_fail[j] = (res_code[2*j +: 2] == 2'b10);
   end

   // R2
   unk_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_unk == '0) |-> (cmp_unk == '0));

   for (genvar j = 0; j < M_OUT; j++) begin : g_bit
      // R4
      exp_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_en && exp_unk[j]) |=> (res_code[2*j +: 2] == 2'b11));
      // R5
      act_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_en && cmp_unk[j]) |=> (res_code[2*j +: 2] == 2'b11));
   end

   // R6
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> (!res_vld && res_code == '0));

   // R7
   cyc_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_fail == (seen_fail != '0));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pat_end |=> pat_done);

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pat_end |=> !pat_done);

   // R9
   verdict_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_start && !pat_end) |=> !pat_fail);

   // R9
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pat_start && !pat_end) |=> $stable(pat_fail));

endmodule

bind xtol_compactor xtol_compactor_chk #(
   .N_IN  (N_IN),
   .M_OUT (M_OUT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .resp_unk  (resp_unk),
   .exp_unk   (exp_unk),
   .cmp_en    (cmp_en),
   .pat_start (pat_start),
   .pat_end   (pat_end),
   .cmp_unk   (cmp_unk),
   .res_vld   (res_vld),
   .res_code  (res_code),
   .cyc_fail  (cyc_fail),
   .pat_done  (pat_done),
   .pat_fail  (pat_fail)
);

// File: tb/xtol_compactor_tb_top.sv
module xtol_compactor_tb_top;

   localparam int N = 8;
   localparam int M = 5;
   localparam logic [N*M-1:0] MAT = {
      5'b10110, 5'b01110, 5'b11001, 5'b10101,
      5'b01101, 5'b10011, 5'b01011, 5'b00111
   };
   localparam time CLK_PERIOD = 10ns;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   resp_val = '0, resp_unk = '0;
   logic [M-1:0]   exp_val = '0, exp_unk = '0;
   logic           cmp_en = 1'b0, pat_start = 1'b0, pat_end = 1'b0;
   logic [M-1:0]   cmp_val, cmp_unk;
   logic           res_vld, cyc_fail, pat_done, pat_fail;
   logic [2*M-1:0] res_code;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xtol_compactor #(.N_IN(N), .M_OUT(M), .MATRIX(MAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .resp_val(resp_val), .resp_unk(resp_unk),
      .exp_val(exp_val), .exp_unk(exp_unk), .cmp_en(cmp_en),
      .pat_start(pat_start), .pat_end(pat_end), .cmp_val(cmp_val),
      .cmp_unk(cmp_unk), .res_vld(res_vld), .res_code(res_code),
      .cyc_fail(cyc_fail), .pat_done(pat_done), .pat_fail(pat_fail)
   );

   function automatic logic [M-1:0] ref_val(logic [N-1:0] r);
      logic [M-1:0] c = '0;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < M; j++)
            if (MAT[i*M+j]) c[j] = c[j] ^ r[i];
      return c;
   endfunction

   function automatic logic [M-1:0] ref_unk(logic [N-1:0] u);
      logic [M-1:0] c = '0;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < M; j++)
            if (MAT[i*M+j] && u[i]) c[j] = 1'b1;
      return c;
   endfunction

   function automatic logic [2*M-1:0] ref_code(logic [N-1:0] rv, logic [N-1:0] ru,
                                               logic [M-1:0] ev, logic [M-1:0] eu);
      logic [2*M-1:0] k = '0;
      logic [M-1:0] a = ref_val(rv);
      logic [M-1:0] au = ref_unk(ru);
      for (int j = 0; j < M; j++) begin
         if (eu[j] || au[j])   k[2*j +: 2] = 2'b11;
         else if (a[j] == ev[j]) k[2*j +: 2] = 2'b01;
         else                  k[2*j +: 2] = 2'b10;
      end
      return k;
   endfunction

   function automatic logic any_fail(logic [2*M-1:0] k);
      for (int j = 0; j < M; j++) if (k[2*j +: 2] == 2'b10) return 1'b1;
      return 1'b0;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic set_in(logic [N-1:0] rv, logic [N-1:0] ru, logic [M-1:0] ev,
                         logic [M-1:0] eu, logic en, logic ps, logic pe);
      resp_val = rv; resp_unk = ru; exp_val = ev; exp_unk = eu;
      cmp_en = en; pat_start = ps; pat_end = pe;
   endtask

   task automatic t_reset();
      @(negedge clk);
      // R10
      chk("R10 res_vld", res_vld, 0);
      chk("R10 res_code", res_code, 0);
      chk("R10 cyc_fail", cyc_fail, 0);
      chk("R10 pat_done", pat_done, 0);
      chk("R10 pat_fail", pat_fail, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_xor();
      logic [N-1:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5A};
      foreach (pats[k]) begin
         @(negedge clk);
         set_in(pats[k], '0, '0, '0, 0, 0, 0);
         #1;
         chk("R1 xor", cmp_val, ref_val(pats[k]));
         chk("R2 no unk", cmp_unk, 0);
      end
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         set_in(N'(1) << i, '0, '0, '0, 0, 0, 0);
         #1;
         chk("R1 single", cmp_val, ref_val(N'(1) << i));
         // R11
         chk("R11 row reaches output", (cmp_val != 0), 1);
      end
   endtask

   task automatic t_unk();
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         set_in(8'hC3, N'(1) << i, '0, '0, 0, 0, 0);
         #1;
         chk("R2 single unk", cmp_unk, ref_unk(N'(1) << i));
      end
      @(negedge clk);
      set_in(8'h00, 8'h11, '0, '0, 0, 0, 0);
      #1;
      chk("R2 two unk", cmp_unk, ref_unk(8'h11));
   endtask

   task automatic t_judge(logic [N-1:0] rv, logic [N-1:0] ru, logic [M-1:0] ev,
                          logic [M-1:0] eu, string tag);
      logic [2*M-1:0] k = ref_code(rv, ru, ev, eu);
      @(negedge clk);
      set_in(rv, ru, ev, eu, 1, 0, 0);
      @(negedge clk);
      set_in('0, '0, '0, '0, 0, 0, 0);
      chk({tag, " vld"}, res_vld, 1);
      chk({tag, " code"}, res_code, k);
      // R7
      chk("R7 cyc_fail", cyc_fail, any_fail(k));
   endtask

   task automatic t_compare();
      logic [M-1:0] g = ref_val(8'h96);
      t_judge(8'h96, '0, g, '0, "R3 all pass");
      t_judge(8'h96, '0, g ^ 5'b00101, '0, "R3 two fail");
      t_judge(8'h96, '0, g ^ 5'b11111, 5'b01010, "R4 exp unk");
      chk("R4 masked code", res_code[3:2], 2'b11);
      t_judge(8'h96, 8'h01, g ^ 5'b00111, '0, "R5 act unk");
      t_judge(8'h2D, '0, ~ref_val(8'h2D), 5'b11111, "R4 all ignored");
      // R6
      @(negedge clk);
      chk("R6 idle vld", res_vld, 0);
      chk("R6 idle code", res_code, 0);
   endtask

   task automatic t_pattern();
      logic [M-1:0] g = ref_val(8'h5A);
      // fail inside start cycle
      @(negedge clk); set_in(8'h5A, '0, ~g, '0, 1, 1, 0);
      @(negedge clk); set_in(8'h5A, '0, g, '0, 1, 0, 0);
      @(negedge clk); set_in(8'h5A, '0, g, '0, 1, 0, 1);
      @(negedge clk); set_in('0, '0, '0, '0, 0, 0, 0);
      chk("R8 done pulse", pat_done, 1);
      chk("R8 fail in start cycle", pat_fail, 1);
      @(negedge clk);
      chk("R8 done one cycle", pat_done, 0);
      chk("R9 verdict held", pat_fail, 1);
      // clean pattern
      @(negedge clk); set_in(8'h5A, '0, g, '0, 1, 1, 0);
      @(negedge clk); set_in(8'h5A, '0, g, '0, 1, 0, 0);
      chk("R9 cleared by start", pat_fail, 0);
      @(negedge clk); set_in(8'h5A, '0, g, '0, 1, 0, 1);
      @(negedge clk); set_in('0, '0, '0, '0, 0, 0, 0);
      chk("R8 clean pattern", pat_fail, 0);
      chk("R8 clean done", pat_done, 1);
      // fail only in end cycle
      @(negedge clk); set_in(8'h5A, '0, g, '0, 1, 1, 0);
      @(negedge clk); set_in(8'h5A, '0, g ^ 5'b10000, '0, 1, 0, 1);
      @(negedge clk); set_in('0, '0, '0, '0, 0, 0, 0);
      chk("R8 fail in end cycle", pat_fail, 1);
      // ignored mismatch does not fail a pattern
      @(negedge clk); set_in(8'h5A, '0, ~g, 5'b11111, 1, 1, 1);
      @(negedge clk); set_in('0, '0, '0, '0, 0, 0, 0);
      chk("R4 ignored pattern passes", pat_fail, 0);
   endtask

   initial begin
      t_reset();
      t_xor();
      t_unk();
      t_compare();
      t_pattern();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule